// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservations that pair a load-linked access with a later store-conditional to the same cache line. A pipeline feeds it one completed write-class operation per cycle through a strobe. Each operation carries a line address, an operation code and a requester id. A separate input reports that coherence permission for a line was lost. The monitor holds a small table of lock entries, each with a line address and an owning requester. It updates that table in the cycle of the strobe. One cycle later it returns a reply that carries the store-conditional outcome and the downstream issue class of the operation.

A load-linked sets or refreshes the lock for its line. A store-conditional succeeds only while its line is still locked by the same requester, and it always drops that lock. An ordinary write from the lock owner drops the lock. A coherence loss drops the lock whatever the owner. When the table is full, a new line takes the entry whose lock was set least recently.

The reply is produced by a two-state phase machine. PH_IDLE moves to PH_REPLY on a legal strobe. PH_REPLY stays in PH_REPLY when another legal strobe arrives in the same cycle (back to back). PH_REPLY falls back to PH_IDLE when there is no legal strobe. PH_IDLE stays in PH_IDLE while nothing legal arrives.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no line is locked and `rsp_valid` is 0, so a store-conditional issued first fails.
- R2: A load-linked (code 1) always replies `rsp_ok`=1 and locks its line for `op_id`.
- R3: A store-conditional (code 2) replies `rsp_sc`=1. It replies `rsp_ok`=1 only when its line is locked by the same `op_id`, and `rsp_ok`=0 otherwise.
- R4: Every store-conditional drops the lock on its line, whether it succeeds or fails.
- R5: An ordinary write (store code 0, locked read code 3, locked write code 4, flush code 5) drops the lock on its line only when the lock owner equals `op_id`. Writes from other requesters leave the lock in place. Ordinary writes reply `rsp_ok`=1.
- R6: A coherence loss (`lost_valid` with `lost_line`) drops the lock on that line. A loss on the same line in the same cycle as a store-conditional makes it fail. A loss in the same cycle as a load-linked on that line leaves the line unlocked.
- R7: `rsp_atomic` is 1 for load-linked and store-conditional and 0 for the ordinary write codes.
- R8: A legal strobe gives exactly one reply, with `rsp_valid`=1 in the next cycle. With no strobe, `rsp_valid` is 0 in the next cycle. Back-to-back strobes give back-to-back replies.
- R9: A load-linked to a line that is already locked replaces that entry's owner. Otherwise it uses a free entry. When all `N_LOCKS` entries are held, it replaces the entry whose lock was set or refreshed least recently.
- R10: Codes 6 and 7 are reserved. They produce no reply and leave every lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (0 store, 1 load-linked, 2 store-conditional, 3 locked read, 4 locked write, 5 flush) |
| op_line | input | LINE_W | Line address of the operation |
| op_id | input | ID_W | Requester id |
| lost_valid | input | 1 | Coherence permission lost this cycle |
| lost_line | input | LINE_W | Line whose permission was lost |
| rsp_valid | output | 1 | Reply for the operation of the previous cycle |
| rsp_sc | output | 1 | Reply belongs to a store-conditional |
| rsp_ok | output | 1 | Success; 0 only for a failed store-conditional |
| rsp_atomic | output | 1 | Operation is issued downstream as an atomic (1) or as a store (0) |

## Verification
The assertions assume that `op_code` is valid whenever `op_valid` is high and that `lost_line` has meaning only while `lost_valid` is high. They also assume that each reply is caused by the strobe one cycle earlier. The stimulus drives every code, including the reserved ones, and keeps line addresses and ids within small ranges so that locks collide often. A reference table in the bench tracks lock order by a running stamp. Directed sequences cover an intervening write, a loss in the same cycle as a load-linked or store-conditional, and eviction when the table is full.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        OP_WRITE   = 3'd0,
        OP_LINK    = 3'd1,
        OP_COND    = 3'd2,
        OP_LOCK_RD = 3'd3,
        OP_LOCK_WR = 3'd4,
        OP_FLUSH   = 3'd5
    } op_code_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_REPLY = 1'b1
    } phase_e;

    typedef struct packed {
        logic legal;
        logic is_link;
        logic is_cond;
        logic is_plain;
        logic atomic;
    } op_class_t;

endpackage

// File: rtl/llsc_op_decode.sv
module llsc_op_decode
    import llsc_pkg::*;
(
    input  logic [2:0] code_i,
    output op_class_t  cls_o
);
    always_comb begin
        cls_o = '0;
        case (code_i)
            OP_LINK: begin
                cls_o.legal   = 1'b1;
                cls_o.is_link = 1'b1;
                cls_o.atomic  = 1'b1;
            end
            OP_COND: begin
                cls_o.legal   = 1'b1;
                cls_o.is_cond = 1'b1;
                cls_o.atomic  = 1'b1;
            end
            OP_WRITE, OP_LOCK_RD, OP_LOCK_WR, OP_FLUSH: begin
                cls_o.legal    = 1'b1;
                cls_o.is_plain = 1'b1;
            end
            default: cls_o = '0;
        endcase
    end
endmodule

// File: rtl/llsc_lock_table.sv
module llsc_lock_table #(
    parameter int N_LOCKS = 4,
    parameter int LINE_W  = 26,
    parameter int ID_W    = 4,
    localparam int IDX_W  = (N_LOCKS > 1) ? $clog2(N_LOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic [LINE_W-1:0]  set_line,
    input  logic [ID_W-1:0]    set_owner,
    input  logic [N_LOCKS-1:0] clr_mask,
    input  logic [LINE_W-1:0]  cmp_line,
    input  logic [ID_W-1:0]    cmp_id,
    input  logic [LINE_W-1:0]  loss_line,
    output logic [N_LOCKS-1:0] valid_vec,
    output logic [N_LOCKS-1:0] hit_vec,
    output logic [N_LOCKS-1:0] own_vec,
    output logic [N_LOCKS-1:0] loss_vec
);
    logic [LINE_W-1:0] line_q  [N_LOCKS];
    logic [ID_W-1:0]   owner_q [N_LOCKS];
    logic [N_LOCKS-1:0] valid_q;

    for (genvar e = 0; e < N_LOCKS; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e]  <= 1'b0;
                line_q[e]   <= '0;
                owner_q[e]  <= '0;
            end else if (set_en && (set_idx == IDX_W'(e))) begin
                valid_q[e]  <= 1'b1;
                line_q[e]   <= set_line;
                owner_q[e]  <= set_owner;
            end else if (clr_mask[e]) begin
                valid_q[e]  <= 1'b0;
            end
        end

        assign hit_vec[e]  = valid_q[e] && (line_q[e] == cmp_line);
        assign own_vec[e]  = hit_vec[e] && (owner_q[e] == cmp_id);
        assign loss_vec[e] = valid_q[e] && (line_q[e] == loss_line);
    end

    assign valid_vec = valid_q;
endmodule

// File: rtl/llsc_age_matrix.sv
module llsc_age_matrix #(
    parameter int N_LOCKS = 4,
    localparam int IDX_W  = (N_LOCKS > 1) ? $clog2(N_LOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [N_LOCKS-1:0] valid_vec,
    output logic               free_any,
    output logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   victim_idx
);
    // older_q[i][j] set: entry i was touched before entry j
    logic [N_LOCKS-1:0] older_q [N_LOCKS];
    logic [N_LOCKS-1:0] oldest_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LOCKS; i++) older_q[i] <= '0;
        end else if (touch_en) begin
            for (int i = 0; i < N_LOCKS; i++) begin
                for (int j = 0; j < N_LOCKS; j++) begin
                    if (i != j) begin
                        if (touch_idx == IDX_W'(i))      older_q[i][j] <= 1'b0;
                        else if (touch_idx == IDX_W'(j)) older_q[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_LOCKS; i++) begin
            oldest_vec[i] = valid_vec[i];
            for (int j = 0; j < N_LOCKS; j++) begin
                if ((i != j) && valid_vec[j] && older_q[j][i]) oldest_vec[i] = 1'b0;
            end
        end
    end

    always_comb begin
        free_any   = ~&valid_vec;
        free_idx   = '0;
        victim_idx = '0;
        for (int i = N_LOCKS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx   = IDX_W'(i);
            if (oldest_vec[i]) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int N_LOCKS = 4,
    parameter int LINE_W  = 26,
    parameter int ID_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [LINE_W-1:0] op_line,
    input  logic [ID_W-1:0]   op_id,
    input  logic              lost_valid,
    input  logic [LINE_W-1:0] lost_line,
    output logic              rsp_valid,
    output logic              rsp_sc,
    output logic              rsp_ok,
    output logic              rsp_atomic
);
    localparam int IDX_W = (N_LOCKS > 1) ? $clog2(N_LOCKS) : 1;

    op_class_t          cls;
    logic               take;
    logic               lost_same;
    logic [N_LOCKS-1:0] valid_vec, hit_vec, own_vec, loss_vec, clr_mask;
    logic               link_hit;
    logic [IDX_W-1:0]   hit_idx, free_idx, victim_idx, set_idx;
    logic               free_any, set_en, cond_ok;

    phase_e state_q, state_d;
    logic   rep_sc_q, rep_ok_q, rep_atomic_q;

    llsc_op_decode u_dec (
        .code_i (op_code),
        .cls_o  (cls)
    );

    assign take      = op_valid && cls.legal;
    assign lost_same = lost_valid && (lost_line == op_line);

    llsc_lock_table #(
        .N_LOCKS (N_LOCKS),
        .LINE_W  (LINE_W),
        .ID_W    (ID_W)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en),
        .set_idx   (set_idx),
        .set_line  (op_line),
        .set_owner (op_id),
        .clr_mask  (clr_mask),
        .cmp_line  (op_line),
        .cmp_id    (op_id),
        .loss_line (lost_line),
        .valid_vec (valid_vec),
        .hit_vec   (hit_vec),
        .own_vec   (own_vec),
        .loss_vec  (loss_vec)
    );

    llsc_age_matrix #(
        .N_LOCKS (N_LOCKS)
    ) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (set_en),
        .touch_idx  (set_idx),
        .valid_vec  (valid_vec),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .victim_idx (victim_idx)
    );

    // entry already holding the operation's line, lowest index
    always_comb begin
        hit_idx = '0;
        for (int i = N_LOCKS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign link_hit = |hit_vec;
    assign cond_ok  = (|own_vec) && !lost_same;
    assign set_en   = take && cls.is_link && !lost_same;
    assign set_idx  = link_hit ? hit_idx : (free_any ? free_idx : victim_idx);

    always_comb begin
        clr_mask = '0;
        if (take && cls.is_cond)  clr_mask = clr_mask | hit_vec;
        if (take && cls.is_plain) clr_mask = clr_mask | own_vec;
        if (lost_valid)           clr_mask = clr_mask | loss_vec;
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  state_d = take ? PH_REPLY : PH_IDLE;
            PH_REPLY: state_d = take ? PH_REPLY : PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
    end

    // reply content captured with the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_sc_q     <= 1'b0;
            rep_ok_q     <= 1'b0;
            rep_atomic_q <= 1'b0;
        end else if (take) begin
            rep_sc_q     <= cls.is_cond;
            rep_ok_q     <= cls.is_cond ? cond_ok : 1'b1;
            rep_atomic_q <= cls.atomic;
        end
    end

    // outputs
    always_comb begin
        rsp_valid  = 1'b0;
        rsp_sc     = 1'b0;
        rsp_ok     = 1'b0;
        rsp_atomic = 1'b0;
        unique case (state_q)
            PH_IDLE: ;
            PH_REPLY: begin
                rsp_valid  = 1'b1;
                rsp_sc     = rep_sc_q;
                rsp_ok     = rep_ok_q;
                rsp_atomic = rep_atomic_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int LINE_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [LINE_W-1:0] op_line,
    input logic              lost_valid,
    input logic [LINE_W-1:0] lost_line,
    input logic              rsp_valid,
    input logic              rsp_sc,
    input logic              rsp_ok,
    input logic              rsp_atomic
);
    logic legal_in;
    assign legal_in = op_valid && (op_code <= 3'd5);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid) else $error("reset reply"); // R1

    AST_LINK_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1) |=> (rsp_valid && rsp_ok && !rsp_sc)); // R2

    AST_COND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2) |=> (rsp_valid && rsp_sc)); // R3

    AST_PLAIN_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_in && op_code != 3'd1 && op_code != 3'd2) |=> (rsp_ok && !rsp_sc)); // R5

    AST_LOSS_KILLS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2 && lost_valid && lost_line == op_line)
        |=> !rsp_ok); // R6

    AST_ATOMIC_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> (rsp_atomic == $past(op_code == 3'd1 || op_code == 3'd2))); // R7

    AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        legal_in |=> rsp_valid); // R8

    AST_NO_STRAY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_in |=> !rsp_valid); // R10
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_line    (op_line),
    .lost_valid (lost_valid),
    .lost_line  (lost_line),
    .rsp_valid  (rsp_valid),
    .rsp_sc     (rsp_sc),
    .rsp_ok     (rsp_ok),
    .rsp_atomic (rsp_atomic)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 26;
    localparam int ID_W       = 4;
    localparam int NL         = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [2:0]        op_code = '0;
    logic [LINE_W-1:0] op_line = '0;
    logic [ID_W-1:0]   op_id = '0;
    logic              lost_valid = 1'b0;
    logic [LINE_W-1:0] lost_line = '0;
    logic rsp_valid, rsp_sc, rsp_ok, rsp_atomic;

    int n_checks = 0;
    int n_fails  = 0;

    // reference lock table
    bit mv [NL];
    int ml [NL];
    int mo [NL];
    int ms [NL];
    int stamp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.N_LOCKS(NL), .LINE_W(LINE_W), .ID_W(ID_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_line(op_line), .op_id(op_id), .lost_valid(lost_valid),
        .lost_line(lost_line), .rsp_valid(rsp_valid), .rsp_sc(rsp_sc),
        .rsp_ok(rsp_ok), .rsp_atomic(rsp_atomic)
    );

    task automatic model_clear();
        for (int i = 0; i < NL; i++) mv[i] = 0;
    endtask

    // expected reply = {valid, sc, ok, atomic}
    function automatic logic [3:0] model_step(bit v, int code, int line, int id,
                                              bit lv, int lline);
        logic [3:0] e = 4'b0;
        bit legal = v && (code <= 5);
        bit lsame = lv && (lline == line);
        int h = -1;
        for (int i = 0; i < NL; i++) if (mv[i] && ml[i] == line) h = i;
        if (legal) begin
            e[3] = 1'b1;
            e[0] = (code == 1 || code == 2);
            if (code == 2) begin
                e[2] = 1'b1;
                e[1] = (h >= 0) && (mo[h] == id) && !lsame;
                if (h >= 0) mv[h] = 0;
            end else if (code == 1) begin
                e[1] = 1'b1;
                if (!lsame) begin
                    int slot = h;
                    if (slot < 0) for (int i = NL - 1; i >= 0; i--) if (!mv[i]) slot = i;
                    if (slot < 0) begin
                        slot = 0;
                        for (int i = 1; i < NL; i++) if (ms[i] < ms[slot]) slot = i;
                    end
                    stamp++;
                    mv[slot] = 1; ml[slot] = line; mo[slot] = id; ms[slot] = stamp;
                end
            end else begin
                e[1] = 1'b1;
                if (h >= 0 && mo[h] == id) mv[h] = 0;
            end
        end
        if (lv) for (int i = 0; i < NL; i++) if (mv[i] && ml[i] == lline) mv[i] = 0;
        return e;
    endfunction

    task automatic apply(bit v, int code, int line, int id, bit lv, int lline, string tag);
        logic [3:0] exp_r, got;
        op_valid   = v;
        op_code    = 3'(code);
        op_line    = LINE_W'(line);
        op_id      = ID_W'(id);
        lost_valid = lv;
        lost_line  = LINE_W'(lline);
        exp_r = model_step(v, code, line, id, lv, lline);
        @(posedge clk);
        @(negedge clk);
        got = {rsp_valid, rsp_sc, rsp_ok, rsp_atomic};
        if (!exp_r[3]) got[2:0] = 3'b0;
        n_checks++;
        if (got !== exp_r) begin
            n_fails++;
            $display("FAIL %s: {valid,sc,ok,atomic} actual %b expected %b (code %0d line %0d id %0d)",
                     tag, got, exp_r, code, line, id);
        end
    endtask

    task automatic idle(string tag);
        apply(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL R8: watchdog expired, actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reply quiet while held in reset
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: rsp_valid actual %b expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        idle("R1");
        apply(1, 2, 9, 1, 0, 0, "R1");            // cond with no lock fails

        // R2/R3/R4: link then cond, repeated cond fails
        apply(1, 1, 10, 1, 0, 0, "R2");
        apply(1, 2, 10, 1, 0, 0, "R3");
        apply(1, 2, 10, 1, 0, 0, "R4");
        // R3/R4: foreign cond fails and still clears
        apply(1, 1, 11, 1, 0, 0, "R2");
        apply(1, 2, 11, 2, 0, 0, "R3");
        apply(1, 2, 11, 1, 0, 0, "R4");
        // R5: intervening write by owner breaks the pair
        apply(1, 1, 12, 3, 0, 0, "R2");
        apply(1, 0, 12, 3, 0, 0, "R5");
        apply(1, 2, 12, 3, 0, 0, "R5");
        // R5: write by another requester leaves the lock
        apply(1, 1, 12, 3, 0, 0, "R2");
        apply(1, 0, 12, 4, 0, 0, "R5");
        apply(1, 4, 12, 5, 0, 0, "R5");
        apply(1, 2, 12, 3, 0, 0, "R5");
        // R5: flush and locked read by owner clear
        apply(1, 1, 13, 2, 0, 0, "R2");
        apply(1, 5, 13, 2, 0, 0, "R5");
        apply(1, 2, 13, 2, 0, 0, "R5");
        apply(1, 1, 13, 2, 0, 0, "R2");
        apply(1, 3, 13, 2, 0, 0, "R5");
        apply(1, 2, 13, 2, 0, 0, "R5");
        // R6: coherence loss
        apply(1, 1, 14, 1, 0, 0, "R2");
        apply(0, 0, 0, 0, 1, 14, "R6");
        apply(1, 2, 14, 1, 0, 0, "R6");
        apply(1, 1, 14, 1, 0, 0, "R2");
        apply(1, 2, 14, 1, 1, 14, "R6");          // loss same cycle as cond
        apply(1, 1, 15, 1, 1, 15, "R6");          // loss same cycle as link
        apply(1, 2, 15, 1, 0, 0, "R6");
        apply(1, 1, 16, 1, 1, 17, "R6");          // unrelated loss
        apply(1, 2, 16, 1, 0, 0, "R6");
        // R9: same-line link replaces owner
        apply(1, 1, 20, 1, 0, 0, "R9");
        apply(1, 1, 20, 2, 0, 0, "R9");
        apply(1, 2, 20, 1, 0, 0, "R9");
        // R9: full table evicts least recently set
        for (int k = 0; k < 4; k++) apply(1, 1, 30 + k, k, 0, 0, "R9");
        apply(1, 1, 34, 7, 0, 0, "R9");
        apply(1, 2, 30, 0, 0, 0, "R9");
        apply(1, 2, 31, 1, 0, 0, "R9");
        // R9: refresh changes the victim
        model_clear();
        for (int k = 0; k < 4; k++) apply(1, 1, 40 + k, k, 0, 0, "R9"); // evicts leftovers
        apply(1, 1, 40, 0, 0, 0, "R9");
        apply(1, 1, 44, 6, 0, 0, "R9");
        apply(1, 2, 41, 1, 0, 0, "R9");
        apply(1, 2, 40, 0, 0, 0, "R9");
        // R10: reserved codes do nothing
        apply(1, 1, 50, 2, 0, 0, "R2");
        apply(1, 6, 50, 2, 0, 0, "R10");
        apply(1, 7, 50, 3, 0, 0, "R10");
        apply(1, 2, 50, 2, 0, 0, "R10");
        // R7/R8: back to back and idle gaps
        apply(1, 3, 51, 1, 0, 0, "R7");
        apply(1, 1, 51, 1, 0, 0, "R7");
        idle("R8");
        idle("R8");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit v  = ($urandom % 10) != 0;
            int c  = $urandom % 8;
            int ln = $urandom % 6;
            int id = $urandom % 3;
            bit lv = ($urandom % 7) == 0;
            int ll = $urandom % 6;
            string tg;
            if (!v || c > 5) tg = "R10";
            else if (c == 1) tg = "R2";
            else if (c == 2) tg = "R3";
            else tg = "R5";
            apply(v, c, ln, id, lv, ll, tg);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule